// File: doc/BRIEF.md
# Sub-word register aperture

This block is the memory-mapped front end of a 64-source interrupt controller. A requester presents reads and writes of 1, 2, 4 or 8 bytes through one of three address windows. The block turns each access into a byte-lane operation against a 64-bit register, chosen by the address with its low three bits cleared. Narrow writes therefore merge into wide registers without disturbing the other bytes. The block holds the configuration registers and both per-source byte tables. It drives them out to the interrupt evaluation logic, takes the raw in-service vector as an input, and emits a one-cycle clear strobe. The evaluation logic itself lives elsewhere.

The request side uses a valid/ready handshake. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` drops for exactly one cycle while an 8-byte access to a 32-bit window runs its second half. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low. The response side has no back-pressure: `rsp_valid` is a single-cycle strobe, and the requester must take it in that cycle.

Window selection (`req_win`): 0 is the low 32-bit window (span 0x100, based at internal address 0x000). 1 is the byte window (span 0x2A0, based at 0x100). 2 is the high 32-bit window (span 0xC60, based at 0x3A0). The internal layout is: identity 0x000, mask 0x020, message-enable 0x040, trigger-mode 0x060, clear 0x080, the two auto-control words 0x0C0 and 0x0E0, routing table 0x100 (one byte per source), vector table 0x200 (one byte per source), status 0x3A0 and polarity 0x3E0.

Top module: `subword_aperture`

## Requirements
- R1: While reset is asserted and after it is released, the mask register is all ones, and trigger-mode, message-enable, polarity and both tables are zero. `rsp_valid` and `clr_valid` are low and `req_ready` is high.
- R2: Read data equals the addressed 64-bit register shifted right by 8 × addr[2:0], then masked to the access width. All bits above the width are zero.
- R3: A write stores (old AND NOT lanes) OR ((wdata AND widthmask) << 8 × addr[2:0]), where lanes = widthmask << 8 × addr[2:0] truncated to 64 bits. Bytes outside the lanes keep their value.
- R4: `req_size` holds the byte count. Windows 0 and 2 accept only 4 and 8, and window 1 accepts only 1. Any other size, window value 3, or an access whose last byte lies past the window span is rejected: it has no effect and returns `rsp_err`=1 with zero data.
- R5: An 8-byte access on window 0 or 2 runs as two 4-byte operations, the lower address first, then address+4. Read data is little-endian: the lower half goes in bits 31:0. Each half succeeds or fails on its own, and `rsp_err` is the OR of both halves. The response comes two cycles after acceptance.
- R6: Window 1 offset 0 maps to routing byte 0, and offset 0x100 maps to vector byte 0. Window 2 offset 0 maps to status and offset 0x40 maps to polarity.
- R7: Status reads return `status_in` AND NOT mask. Status is read-only, so a write to it is an error.
- R8: The auto-control words read as zero and ignore writes, with no error.
- R9: Unmapped words, writes to identity or status, and reads of the clear word return an error and zero data, and change no register.
- R10: A write to the clear word stores nothing. It pulses `clr_valid` for one cycle, one cycle after the operation, with `clr_bits` = the lane-shifted, width-masked write data.
- R11: A single-operation access responds exactly one cycle after acceptance. `rsp_valid` stays high for one cycle only.
- R12: The `cfg_*` outputs show the stored registers and tables. Byte k of a table sits at bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (low during a split second half) |
| req_win | input | 2 | Window select: 0 low, 1 byte, 2 high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset within the window |
| req_size | input | 4 | Access width in bytes |
| req_wdata | input | 64 | Write data, least significant byte first |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access rejected or partly rejected |
| rsp_rdata | output | 64 | Aligned read data (zero for writes) |
| status_in | input | 64 | Raw in-service vector from the evaluation logic |
| clr_valid | output | 1 | Clear strobe |
| clr_bits | output | 64 | Bits to clear |
| cfg_mask | output | 64 | Mask register |
| cfg_edge | output | 64 | Trigger-mode register |
| cfg_msien | output | 64 | Message-enable register |
| cfg_pol | output | 64 | Polarity register |
| cfg_route | output | 512 | Routing table, byte per source |
| cfg_vec | output | 512 | Vector table, byte per source |

## Verification
Every single-operation access, including rejected ones, responds one cycle after the accepting edge. A split 8-byte access keeps `req_ready` low in the following cycle and responds in the one after that. The clear strobe appears one cycle after the write edge, and the `cfg_*` outputs change at that same write edge. The bench drives requests at falling edges and samples every output at falling edges. It counts the falling edges from acceptance to the response, and compares that count with the latency each vector expects. It also confirms that the strobe drops on the following falling edge.

// File: rtl/subap_pkg.sv
package subap_pkg;
  localparam int ADDR_W = 12;
  localparam int FLAT_W = 13;
  localparam int DW     = 64;

  localparam logic [1:0] WIN_LOW  = 2'd0;
  localparam logic [1:0] WIN_BYTE = 2'd1;
  localparam logic [1:0] WIN_HIGH = 2'd2;

  localparam logic [FLAT_W-1:0] BASE_LOW  = 13'h000;
  localparam logic [FLAT_W-1:0] BASE_BYTE = 13'h100;
  localparam logic [FLAT_W-1:0] BASE_HIGH = 13'h3A0;
  localparam logic [FLAT_W-1:0] SPAN_LOW  = 13'h100;
  localparam logic [FLAT_W-1:0] SPAN_BYTE = 13'h2A0;
  localparam logic [FLAT_W-1:0] SPAN_HIGH = 13'hC60;

  localparam logic [FLAT_W-1:0] A_IDENT  = 13'h000;
  localparam logic [FLAT_W-1:0] A_MASK   = 13'h020;
  localparam logic [FLAT_W-1:0] A_MSIEN  = 13'h040;
  localparam logic [FLAT_W-1:0] A_EDGE   = 13'h060;
  localparam logic [FLAT_W-1:0] A_CLEAR  = 13'h080;
  localparam logic [FLAT_W-1:0] A_AUTO0  = 13'h0C0;
  localparam logic [FLAT_W-1:0] A_AUTO1  = 13'h0E0;
  localparam logic [FLAT_W-1:0] A_ROUTE  = 13'h100;
  localparam logic [FLAT_W-1:0] A_VEC    = 13'h200;
  localparam logic [FLAT_W-1:0] A_STATUS = 13'h3A0;
  localparam logic [FLAT_W-1:0] A_POL    = 13'h3E0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_IDENT, SEL_MASK, SEL_MSIEN, SEL_EDGE, SEL_CLEAR,
    SEL_AUTO, SEL_ROUTE, SEL_VEC, SEL_STATUS, SEL_POL
  } sel_e;

  typedef struct packed {
    logic [FLAT_W-1:0] addr;
    logic [3:0]        size;
    logic              wr;
    logic [DW-1:0]     wdata;
  } op_t;

  function automatic logic [DW-1:0] width_mask(input logic [3:0] size);
    case (size)
      4'd1:    width_mask = 64'h0000_0000_0000_00FF;
      4'd2:    width_mask = 64'h0000_0000_0000_FFFF;
      4'd4:    width_mask = 64'h0000_0000_FFFF_FFFF;
      4'd8:    width_mask = '1;
      default: width_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/ap_window_map.sv
module ap_window_map
  import subap_pkg::*;
(
  input  logic [1:0]        win,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output logic              ok,
  output logic              split,
  output logic [FLAT_W-1:0] flat,
  output logic [3:0]        op_size
);
  logic [FLAT_W-1:0] base, span, last;
  logic              wide, win_ok, size_ok;

  always_comb begin
    win_ok = 1'b1;
    wide   = 1'b1;
    base   = BASE_LOW;
    span   = SPAN_LOW;
    case (win)
      WIN_LOW:  begin base = BASE_LOW;  span = SPAN_LOW;  end
      WIN_BYTE: begin base = BASE_BYTE; span = SPAN_BYTE; wide = 1'b0; end
      WIN_HIGH: begin base = BASE_HIGH; span = SPAN_HIGH; end
      default:  win_ok = 1'b0;
    endcase
    size_ok = wide ? (size == 4'd4 || size == 4'd8) : (size == 4'd1);
    last    = {1'b0, addr} + {{(FLAT_W-4){1'b0}}, size};
    ok      = win_ok && size_ok && (last <= span);
    flat    = base + {1'b0, addr};
    split   = wide && (size == 4'd8);
    op_size = split ? 4'd4 : size;
  end
endmodule

// File: rtl/ap_lane_merge.sv
module ap_lane_merge
  import subap_pkg::*;
(
  input  logic [2:0]    off,
  input  logic [3:0]    size,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] old,
  output logic [DW-1:0] rd_val,
  output logic [DW-1:0] merged,
  output logic [DW-1:0] lane_data
);
  logic [DW-1:0] wmask, lanes;
  logic [5:0]    sh;

  always_comb begin
    wmask     = width_mask(size);
    sh        = {off, 3'b000};
    lanes     = wmask << sh;
    lane_data = (wdata & wmask) << sh;
    merged    = (old & ~lanes) | lane_data;
    rd_val    = (old >> sh) & wmask;
  end
endmodule

// File: rtl/ap_reg_bank.sv
module ap_reg_bank
  import subap_pkg::*;
#(
  parameter int            NSRC     = 64,
  parameter logic [DW-1:0] ID_VALUE = 64'h0000_003F_0001_0007
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_en,
  input  op_t             op,
  input  logic [DW-1:0]   status_in,
  output logic [DW-1:0]   rd_val,
  output logic            err,
  output logic            clr_valid,
  output logic [DW-1:0]   clr_bits,
  output logic [DW-1:0]   cfg_mask,
  output logic [DW-1:0]   cfg_edge,
  output logic [DW-1:0]   cfg_msien,
  output logic [DW-1:0]   cfg_pol,
  output logic [NSRC*8-1:0] cfg_route,
  output logic [NSRC*8-1:0] cfg_vec
);
  localparam int TBL_WORDS = NSRC / 8;
  localparam int IDX_W     = (TBL_WORDS > 1) ? $clog2(TBL_WORDS) : 1;
  localparam logic [FLAT_W-1:0] TBL_SPAN = FLAT_W'(NSRC);

  logic [DW-1:0] mask_q, edge_q, msien_q, pol_q;
  logic [DW-1:0] route_q [TBL_WORDS];
  logic [DW-1:0] vec_q   [TBL_WORDS];

  logic [FLAT_W-1:0] word, roff, voff;
  logic [IDX_W-1:0]  ridx, vidx;
  sel_e              sel;
  logic              rd_ok, wr_ok;
  logic [DW-1:0]     old, lm_rd, merged, lane_data;

  always_comb begin
    word = {op.addr[FLAT_W-1:3], 3'b000};
    roff = word - A_ROUTE;
    voff = word - A_VEC;
    ridx = roff[IDX_W+2:3];
    vidx = voff[IDX_W+2:3];
    if (word == A_IDENT)                                   sel = SEL_IDENT;
    else if (word == A_MASK)                               sel = SEL_MASK;
    else if (word == A_MSIEN)                              sel = SEL_MSIEN;
    else if (word == A_EDGE)                               sel = SEL_EDGE;
    else if (word == A_CLEAR)                              sel = SEL_CLEAR;
    else if (word == A_AUTO0 || word == A_AUTO1)           sel = SEL_AUTO;
    else if (word >= A_ROUTE && word < A_ROUTE + TBL_SPAN) sel = SEL_ROUTE;
    else if (word >= A_VEC && word < A_VEC + TBL_SPAN)     sel = SEL_VEC;
    else if (word == A_STATUS)                             sel = SEL_STATUS;
    else if (word == A_POL)                                sel = SEL_POL;
    else                                                   sel = SEL_NONE;

    case (sel)
      SEL_IDENT:  old = ID_VALUE;
      SEL_MASK:   old = mask_q;
      SEL_MSIEN:  old = msien_q;
      SEL_EDGE:   old = edge_q;
      SEL_ROUTE:  old = route_q[ridx];
      SEL_VEC:    old = vec_q[vidx];
      SEL_STATUS: old = status_in & ~mask_q;
      SEL_POL:    old = pol_q;
      default:    old = '0;
    endcase

    rd_ok = (sel != SEL_NONE) && (sel != SEL_CLEAR);
    wr_ok = (sel != SEL_NONE) && (sel != SEL_IDENT) && (sel != SEL_STATUS);
    err   = op_en && (op.wr ? !wr_ok : !rd_ok);
    rd_val = (op_en && !op.wr && rd_ok && sel != SEL_AUTO) ? lm_rd : '0;
  end

  ap_lane_merge u_lane (
    .off       (op.addr[2:0]),
    .size      (op.size),
    .wdata     (op.wdata),
    .old       (old),
    .rd_val    (lm_rd),
    .merged    (merged),
    .lane_data (lane_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      edge_q    <= '0;
      msien_q   <= '0;
      pol_q     <= '0;
      clr_valid <= 1'b0;
      clr_bits  <= '0;
      for (int i = 0; i < TBL_WORDS; i++) begin
        route_q[i] <= '0;
        vec_q[i]   <= '0;
      end
    end else begin
      clr_valid <= 1'b0;
      clr_bits  <= '0;
      if (op_en && op.wr) begin
        case (sel)
          SEL_MASK:  mask_q        <= merged;
          SEL_MSIEN: msien_q       <= merged;
          SEL_EDGE:  edge_q        <= merged;
          SEL_POL:   pol_q         <= merged;
          SEL_ROUTE: route_q[ridx] <= merged;
          SEL_VEC:   vec_q[vidx]   <= merged;
          SEL_CLEAR: begin
            clr_valid <= 1'b1;
            clr_bits  <= lane_data;
          end
          default: ;
        endcase
      end
    end
  end

  assign cfg_mask  = mask_q;
  assign cfg_edge  = edge_q;
  assign cfg_msien = msien_q;
  assign cfg_pol   = pol_q;

  for (genvar g = 0; g < TBL_WORDS; g++) begin : g_flat
    assign cfg_route[g*DW +: DW] = route_q[g];
    assign cfg_vec[g*DW +: DW]   = vec_q[g];
  end

  // R8
  auto_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op.wr && sel == SEL_AUTO) |=>
      ($stable(cfg_mask) && $stable(cfg_edge) && $stable(cfg_msien) && $stable(cfg_pol)));

  // R2
  always_comb begin
    if (rst_n && op_en && !op.wr && op.size == 4'd1)
      narrow_read_chk: assert (rd_val[DW-1:8] == '0);
  end
endmodule

// File: rtl/subword_aperture.sv
module subword_aperture
  import subap_pkg::*;
#(
  parameter int            NSRC     = 64,
  parameter logic [63:0]   ID_VALUE = 64'h0000_003F_0001_0007
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_win,
  input  logic              req_write,
  input  logic [11:0]       req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [63:0]       rsp_rdata,
  input  logic [63:0]       status_in,
  output logic              clr_valid,
  output logic [63:0]       clr_bits,
  output logic [63:0]       cfg_mask,
  output logic [63:0]       cfg_edge,
  output logic [63:0]       cfg_msien,
  output logic [63:0]       cfg_pol,
  output logic [NSRC*8-1:0] cfg_route,
  output logic [NSRC*8-1:0] cfg_vec
);
  typedef enum logic {ST_IDLE, ST_UPPER} st_e;

  st_e               st_q;
  op_t               hold_q, op;
  logic [31:0]       lo_q;
  logic              lo_err_q;
  logic              map_ok, map_split, accept, op_en, bank_err;
  logic [FLAT_W-1:0] map_flat;
  logic [3:0]        map_size;
  logic [DW-1:0]     bank_rd;

  ap_window_map u_map (
    .win     (req_win),
    .addr    (req_addr),
    .size    (req_size),
    .ok      (map_ok),
    .split   (map_split),
    .flat    (map_flat),
    .op_size (map_size)
  );

  always_comb begin
    req_ready = (st_q == ST_IDLE);
    accept    = req_valid && req_ready;
    op_en     = (accept && map_ok) || (st_q == ST_UPPER);
    if (st_q == ST_UPPER) op = hold_q;
    else                  op = '{addr: map_flat, size: map_size, wr: req_write, wdata: req_wdata};
  end

  ap_reg_bank #(.NSRC(NSRC), .ID_VALUE(ID_VALUE)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_en     (op_en),
    .op        (op),
    .status_in (status_in),
    .rd_val    (bank_rd),
    .err       (bank_err),
    .clr_valid (clr_valid),
    .clr_bits  (clr_bits),
    .cfg_mask  (cfg_mask),
    .cfg_edge  (cfg_edge),
    .cfg_msien (cfg_msien),
    .cfg_pol   (cfg_pol),
    .cfg_route (cfg_route),
    .cfg_vec   (cfg_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      hold_q    <= '0;
      lo_q      <= '0;
      lo_err_q  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (st_q == ST_UPPER) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= {bank_rd[31:0], lo_q};
        rsp_err   <= lo_err_q | bank_err;
        st_q      <= ST_IDLE;
      end else if (accept) begin
        if (map_ok && map_split) begin
          hold_q   <= '{addr: map_flat + 13'd4, size: 4'd4, wr: req_write,
                        wdata: {32'b0, req_wdata[63:32]}};
          lo_q     <= bank_rd[31:0];
          lo_err_q <= bank_err;
          st_q     <= ST_UPPER;
        end else begin
          rsp_valid <= 1'b1;
          rsp_rdata <= map_ok ? bank_rd : '0;
          rsp_err   <= !map_ok || bank_err;
        end
      end
    end
  end

  // R11
  single_op_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(map_ok && map_split)) |=> rsp_valid);

  // R5
  split_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && map_ok && map_split) |=> (!req_ready && !rsp_valid) ##1 rsp_valid);

  // R4
  bad_req_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !map_ok) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

  // R11
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && st_q == ST_IDLE && !accept) |=> !rsp_valid);
endmodule

// File: tb/test_subword_aperture.sv
module test_subword_aperture;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_win = '0;
  logic         req_write = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [3:0]   req_size = '0;
  logic [63:0]  req_wdata = '0;
  logic         rsp_valid, rsp_err;
  logic [63:0]  rsp_rdata;
  logic [63:0]  status_in = 64'h00FF_00FF_0F0F_F0F0;
  logic         clr_valid;
  logic [63:0]  clr_bits, cfg_mask, cfg_edge, cfg_msien, cfg_pol;
  logic [511:0] cfg_route, cfg_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  subword_aperture i_subword_aperture (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_win(req_win), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .status_in(status_in),
    .clr_valid(clr_valid), .clr_bits(clr_bits), .cfg_mask(cfg_mask),
    .cfg_edge(cfg_edge), .cfg_msien(cfg_msien), .cfg_pol(cfg_pol),
    .cfg_route(cfg_route), .cfg_vec(cfg_vec)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [1:0]  win;
    logic        wr;
    logic [11:0] addr;
    logic [3:0]  size;
    logic [63:0] wd;
    logic [63:0] exp;
    logic        err;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VECS [NV] = '{
    '{"R5 ", 2'd0, 1'b0, 12'h000, 4'd8, 64'h0, 64'h0000_003F_0001_0007, 1'b0, 2'd2},
    '{"R1 ", 2'd0, 1'b0, 12'h020, 4'd4, 64'h0, 64'hFFFF_FFFF, 1'b0, 2'd1},
    '{"R3 ", 2'd0, 1'b1, 12'h020, 4'd4, 64'h1234_5678, 64'h0, 1'b0, 2'd1},
    '{"R3 ", 2'd0, 1'b0, 12'h024, 4'd4, 64'h0, 64'hFFFF_FFFF, 1'b0, 2'd1},
    '{"R3 ", 2'd0, 1'b0, 12'h020, 4'd4, 64'h0, 64'h1234_5678, 1'b0, 2'd1},
    '{"R5 ", 2'd0, 1'b1, 12'h020, 4'd8, 64'h00FF, 64'h0, 1'b0, 2'd2},
    '{"R5 ", 2'd0, 1'b0, 12'h020, 4'd8, 64'h0, 64'h00FF, 1'b0, 2'd2},
    '{"R7 ", 2'd2, 1'b0, 12'h000, 4'd8, 64'h0, 64'h00FF_00FF_0F0F_F000, 1'b0, 2'd2},
    '{"R7 ", 2'd2, 1'b1, 12'h000, 4'd4, 64'h1, 64'h0, 1'b1, 2'd1},
    '{"R6 ", 2'd1, 1'b1, 12'h005, 4'd1, 64'hAB, 64'h0, 1'b0, 2'd1},
    '{"R6 ", 2'd1, 1'b1, 12'h002, 4'd1, 64'h1C, 64'h0, 1'b0, 2'd1},
    '{"R2 ", 2'd1, 1'b0, 12'h005, 4'd1, 64'h0, 64'hAB, 1'b0, 2'd1},
    '{"R2 ", 2'd1, 1'b0, 12'h002, 4'd1, 64'h0, 64'h1C, 1'b0, 2'd1},
    '{"R3 ", 2'd1, 1'b0, 12'h003, 4'd1, 64'h0, 64'h00, 1'b0, 2'd1},
    '{"R6 ", 2'd1, 1'b1, 12'h107, 4'd1, 64'h3E, 64'h0, 1'b0, 2'd1},
    '{"R6 ", 2'd1, 1'b0, 12'h107, 4'd1, 64'h0, 64'h3E, 1'b0, 2'd1},
    '{"R6 ", 2'd2, 1'b1, 12'h040, 4'd4, 64'hA5A5_0001, 64'h0, 1'b0, 2'd1},
    '{"R6 ", 2'd2, 1'b0, 12'h040, 4'd8, 64'h0, 64'hA5A5_0001, 1'b0, 2'd2},
    '{"R4 ", 2'd1, 1'b0, 12'h004, 4'd4, 64'h0, 64'h0, 1'b1, 2'd1},
    '{"R4 ", 2'd0, 1'b0, 12'h020, 4'd2, 64'h0, 64'h0, 1'b1, 2'd1},
    '{"R4 ", 2'd0, 1'b1, 12'h020, 4'd1, 64'hFF, 64'h0, 1'b1, 2'd1},
    '{"R4 ", 2'd0, 1'b0, 12'h020, 4'd8, 64'h0, 64'h00FF, 1'b0, 2'd2},
    '{"R4 ", 2'd1, 1'b0, 12'h005, 4'd3, 64'h0, 64'h0, 1'b1, 2'd1},
    '{"R4 ", 2'd3, 1'b0, 12'h000, 4'd4, 64'h0, 64'h0, 1'b1, 2'd1},
    '{"R8 ", 2'd0, 1'b1, 12'h0C0, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 2'd2},
    '{"R8 ", 2'd0, 1'b0, 12'h0C0, 4'd8, 64'h0, 64'h0, 1'b0, 2'd2},
    '{"R8 ", 2'd0, 1'b0, 12'h0E4, 4'd4, 64'h0, 64'h0, 1'b0, 2'd1},
    '{"R9 ", 2'd0, 1'b0, 12'h0A0, 4'd4, 64'h0, 64'h0, 1'b1, 2'd1},
    '{"R9 ", 2'd0, 1'b1, 12'h000, 4'd4, 64'h5, 64'h0, 1'b1, 2'd1},
    '{"R9 ", 2'd0, 1'b0, 12'h080, 4'd4, 64'h0, 64'h0, 1'b1, 2'd1},
    '{"R9 ", 2'd1, 1'b0, 12'h040, 4'd1, 64'h0, 64'h0, 1'b1, 2'd1},
    '{"R9 ", 2'd2, 1'b0, 12'hC60, 4'd4, 64'h0, 64'h0, 1'b1, 2'd1},
    '{"R9 ", 2'd0, 1'b0, 12'h0FC, 4'd8, 64'h0, 64'h0, 1'b1, 2'd1},
    '{"R5 ", 2'd0, 1'b0, 12'h01C, 4'd8, 64'h0, 64'h0000_00FF_0000_0000, 1'b1, 2'd2},
    '{"R3 ", 2'd0, 1'b1, 12'h022, 4'd4, 64'hDEAD_BEEF, 64'h0, 1'b0, 2'd1},
    '{"R2 ", 2'd0, 1'b0, 12'h020, 4'd8, 64'h0, 64'h0000_DEAD_BEEF_00FF, 1'b0, 2'd2},
    '{"R3 ", 2'd0, 1'b1, 12'h026, 4'd4, 64'h1111_2222, 64'h0, 1'b0, 2'd1},
    '{"R2 ", 2'd0, 1'b0, 12'h026, 4'd4, 64'h0, 64'h2222, 1'b0, 2'd1},
    '{"R3 ", 2'd0, 1'b0, 12'h020, 4'd8, 64'h0, 64'h2222_DEAD_BEEF_00FF, 1'b0, 2'd2},
    '{"R7 ", 2'd2, 1'b0, 12'h000, 4'd8, 64'h0, 64'h00DD_0052_0100_F000, 1'b0, 2'd2}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] win, input logic wr, input logic [11:0] addr,
                       input logic [3:0] size, input logic [63:0] wd,
                       output logic [63:0] rd, output logic er, output int lat,
                       output logic clrv, output logic [63:0] clrb, output logic stuck);
    @(negedge clk);
    req_win = win; req_write = wr; req_addr = addr; req_size = size;
    req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    clrv = clr_valid;
    clrb = clr_bits;
    lat = 1;
    while (!rsp_valid && lat < 4) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    er = rsp_err;
    @(negedge clk);
    stuck = rsp_valid;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd, clrb;
    logic er, clrv, stuck;
    int lat;

    // R1: state while in reset
    repeat (3) @(negedge clk);
    check(cfg_mask == '1 && cfg_edge == '0 && cfg_pol == '0 && cfg_msien == '0,
          "R1 reset cfg", cfg_mask, 64'hFFFF_FFFF_FFFF_FFFF);
    check(!rsp_valid && !clr_valid && req_ready, "R1 reset handshake",
          {61'b0, rsp_valid, clr_valid, req_ready}, 64'h1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].win, VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wd,
            rd, er, lat, clrv, clrb, stuck);
      // R11 latency and single-cycle strobe, R5 split latency
      checks++;
      if (lat != int'(VECS[i].lat) || stuck) begin
        errors++;
        $display("FAIL %s R11 vec %0d latency actual=%0d expected=%0d stuck=%0b",
                 VECS[i].tag, i, lat, VECS[i].lat, stuck);
      end
      checks++;
      if (rd !== VECS[i].exp || er !== VECS[i].err) begin
        errors++;
        $display("FAIL %s vec %0d actual=%h/%0b expected=%h/%0b",
                 VECS[i].tag, i, rd, er, VECS[i].exp, VECS[i].err);
      end
    end

    // R12: configuration outputs show stored values
    check(cfg_mask == 64'h2222_DEAD_BEEF_00FF, "R12 cfg_mask", cfg_mask, 64'h2222_DEAD_BEEF_00FF);
    check(cfg_pol == 64'hA5A5_0001, "R12 cfg_pol", cfg_pol, 64'hA5A5_0001);
    check(cfg_route[47:40] == 8'hAB && cfg_route[23:16] == 8'h1C, "R12 route bytes",
          {48'b0, cfg_route[47:40], cfg_route[23:16]}, 64'hAB1C);
    check(cfg_vec[63:56] == 8'h3E, "R12 vec byte 7", {56'b0, cfg_vec[63:56]}, 64'h3E);

    issue(2'd0, 1'b1, 12'h060, 4'd8, 64'h8000_0000_0000_0001, rd, er, lat, clrv, clrb, stuck);
    check(cfg_edge == 64'h8000_0000_0000_0001, "R12 cfg_edge", cfg_edge, 64'h8000_0000_0000_0001);
    issue(2'd0, 1'b1, 12'h040, 4'd4, 64'h0000_0003, rd, er, lat, clrv, clrb, stuck);
    check(cfg_msien == 64'h3, "R12 cfg_msien", cfg_msien, 64'h3);

    // R10: clear strobe
    issue(2'd0, 1'b1, 12'h080, 4'd4, 64'h0F00, rd, er, lat, clrv, clrb, stuck);
    check(clrv && clrb == 64'h0F00 && !er, "R10 clear low", clrb, 64'h0F00);
    check(!clr_valid, "R10 clear one cycle", {63'b0, clr_valid}, 64'h0);
    issue(2'd0, 1'b1, 12'h084, 4'd4, 64'h1, rd, er, lat, clrv, clrb, stuck);
    check(clrv && clrb == 64'h1_0000_0000, "R10 clear upper lanes", clrb, 64'h1_0000_0000);
    check(cfg_mask == 64'h2222_DEAD_BEEF_00FF && cfg_edge == 64'h8000_0000_0000_0001,
          "R10 clear stores nothing", cfg_mask, 64'h2222_DEAD_BEEF_00FF);

    // R1: reset again returns defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(cfg_mask == '1 && cfg_edge == '0 && cfg_pol == '0 && cfg_msien == '0
          && cfg_route == '0 && cfg_vec == '0, "R1 mid-run reset", cfg_mask, 64'hFFFF_FFFF_FFFF_FFFF);
    check(req_ready && !rsp_valid, "R1 mid-run handshake", {63'b0, req_ready}, 64'h1);
    rst_n = 1'b1;
    issue(2'd0, 1'b0, 12'h020, 4'd8, 64'h0, rd, er, lat, clrv, clrb, stuck);
    check(rd == '1 && !er, "R1 mask readback after reset", rd, 64'hFFFF_FFFF_FFFF_FFFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule